// File: doc/BRIEF.md
# Addressable Tap Delay Chain

This block is a single-bit delay line for lining up pipeline paths of different latency. It is made of one or more cells, each holding sixteen one-bit stages that move one place on every clock edge where the shift enable is high. A run-time select per cell picks the stage that drives the cell's tap, so one cell gives a delay of 1 to 16 shifts. The selected bit appears at once when the select changes, with no clock edge in between.

Cells are linked in series by a parameter. In tap linking each cell's tap feeds the next cell, and the total delay is the sum of the selected delays. In full linking every cell except the last passes on its sixteenth stage, so the early cells give a fixed sixteen shifts each and only the last cell's select is used. A cascade output always shows the sixteenth stage of the last cell, so several chains can be joined into a longer line. An optional output flop adds one more shift of delay and gives a registered result.

The shift stages have no reset. Their contents at time zero come from a parameter, all zero by default. Only the output flop is cleared by the reset.

Top module: `tapdl_chain`

## Requirements
- R1: Stage j of a cell (j = 0 to 15) holds the bit that entered that cell j+1 enabled edges ago, and `tap_out` shows stage k of the last cell, where k is that cell's select value.
- R2: On a clock edge with `shift_en` low no stage moves, so `cascade_out` and `tap_out_q` keep their values, and `tap_out` also keeps its value while `tap_sel` is unchanged.
- R3: `cascade_out` shows stage 15 of the last cell whatever that cell's select value is.
- R4: A change of `tap_sel` changes `tap_out` in the same cycle, before any clock edge.
- R5: Before the first enabled edge, stage j of every cell holds bit j of `INIT_BITS`. `rst_n` does not change any stage.
- R6: With `OUT_REG` = 1, `tap_out_q` is cleared to 0 on an edge with `rst_n` low. Otherwise it loads `tap_out` on an edge with `shift_en` high and holds on an edge with `shift_en` low, so it runs one shift behind `tap_out`.
- R7: With `LINK_MODE` = LINK_TAP and all selects held, `tap_out` shows the bit that entered `din` S enabled edges ago, where S is the sum of (k_c + 1) over all cells c.
- R8: Cell c takes its select from `tap_sel[4c+3:4c]`, and cell 0 is the cell fed by `din`. With tap linking, `cascade_out` shows the bit that entered `din` (sum over the cells before the last of (k_c + 1)) + 16 enabled edges ago.
- R9: With `LINK_MODE` = LINK_FULL, `tap_out` shows the bit that entered `din` 16·(NUM_CELLS−1) + k_last + 1 enabled edges ago, and the selects of the cells before the last have no effect. With `OUT_REG` = 0, `tap_out_q` equals `tap_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Stages move on its rising edge. |
| rst_n | input | 1 | Active-low synchronous clear of the output flop only. |
| shift_en | input | 1 | High to shift all stages by one place on this edge. |
| din | input | 1 | Serial data into cell 0. |
| tap_sel | input | NUM_CELLS·SEL_W | Per-cell stage select. Cell c uses bits [c·SEL_W +: SEL_W]. |
| tap_out | output | 1 | Combinational tap of the last cell. |
| tap_out_q | output | 1 | Tap after the optional output flop. |
| cascade_out | output | 1 | Sixteenth stage of the last cell, used for chaining. |

## Verification
The bench checks the contents at time zero against a non-zero pattern. A design that cleared its stages, or that bit-reversed the pattern, would show wrong taps during the select sweep. It holds uneven selects across the cells and compares `cascade_out` with a history of inputs. This catches the field order being swapped between cells, which would move the cascade point by several shifts, and it catches a tap linked to the wrong stage, which would be off by one. Long idle stretches with `din` toggling expose a design that shifts without the enable. A second chain in full-link mode with random early selects fails if those selects leak into the path.

// File: rtl/tapdl_pkg.sv
`timescale 1ns/1ps
package tapdl_pkg;
    // Stages per cell; the select width is derived from it.
    localparam int unsigned CELL_DEPTH_DEF = 16;
    localparam int unsigned SEL_W_DEF      = $clog2(CELL_DEPTH_DEF);

    // How a non-final cell feeds the cell after it.
    typedef enum logic {
        LINK_TAP  = 1'b0,   // selected tap feeds the next cell
        LINK_FULL = 1'b1    // sixteenth stage feeds the next cell
    } link_mode_e;
endpackage

// File: rtl/tapdl_tap_mux.sv
`timescale 1ns/1ps
// Read-side selector: picks one stage of a cell. DEPTH must be a power of two.
module tapdl_tap_mux #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] bits,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    always_comb begin
        y = bits[sel];
    end
endmodule

// File: rtl/tapdl_cell.sv
`timescale 1ns/1ps
// One cell: DEPTH stages with no reset, a run-time tap and a fixed last-stage output.
module tapdl_cell #(
    parameter int unsigned     DEPTH     = 16,
    parameter int unsigned     SEL_W     = $clog2(DEPTH),
    parameter logic [DEPTH-1:0] INIT_BITS = '0
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tap,
    output logic             last
);
    // stg[0] is the newest bit, stg[DEPTH-1] the oldest.
    logic [DEPTH-1:0] stg = INIT_BITS;

    always_ff @(posedge clk) begin
        if (shift_en) begin
            stg <= {stg[DEPTH-2:0], ser_in};
        end
    end

    tapdl_tap_mux #(
        .DEPTH (DEPTH),
        .SEL_W (SEL_W)
    ) u_mux (
        .bits (stg),
        .sel  (sel),
        .y    (tap)
    );

    assign last = stg[DEPTH-1];
endmodule

// File: rtl/tapdl_out_stage.sv
`timescale 1ns/1ps
// Optional output flop; moves only on enabled edges, so it counts in shifts.
module tapdl_out_stage #(
    parameter bit REGISTERED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic d,
    output logic q
);
    generate
        if (REGISTERED) begin : g_flop
            logic q_r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= 1'b0;
                end else if (shift_en) begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_pass
            logic unused_pins;
            assign unused_pins = &{1'b0, clk, rst_n, shift_en};
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/tapdl_chain.sv
`timescale 1ns/1ps
// Chain of addressable tap cells with optional output flop.
module tapdl_chain
    import tapdl_pkg::*;
#(
    parameter int unsigned          NUM_CELLS  = 3,
    parameter int unsigned          CELL_DEPTH = CELL_DEPTH_DEF,
    parameter int unsigned          SEL_W      = $clog2(CELL_DEPTH),
    parameter logic [CELL_DEPTH-1:0] INIT_BITS = '0,
    parameter bit                   OUT_REG    = 1'b1,
    parameter link_mode_e           LINK_MODE  = LINK_TAP
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic                       din,
    input  logic [NUM_CELLS*SEL_W-1:0] tap_sel,
    output logic                       tap_out,
    output logic                       tap_out_q,
    output logic                       cascade_out
);
    localparam int unsigned SEL_BUS_W = NUM_CELLS * SEL_W;
    localparam bit          USE_LAST  = (LINK_MODE == LINK_FULL);

    logic [NUM_CELLS-1:0] link_in;
    logic [NUM_CELLS-1:0] cell_tap;
    logic [NUM_CELLS-1:0] cell_last;
    logic [SEL_BUS_W-1:0] sel_bus;

    assign sel_bus    = tap_sel;
    assign link_in[0] = din;

    generate
        for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
            tapdl_cell #(
                .DEPTH     (CELL_DEPTH),
                .SEL_W     (SEL_W),
                .INIT_BITS (INIT_BITS)
            ) u_cell (
                .clk      (clk),
                .shift_en (shift_en),
                .ser_in   (link_in[c]),
                .sel      (sel_bus[c*SEL_W +: SEL_W]),
                .tap      (cell_tap[c]),
                .last     (cell_last[c])
            );
            if (c < NUM_CELLS - 1) begin : g_link
                assign link_in[c+1] = USE_LAST ? cell_last[c] : cell_tap[c];
            end
        end
    endgenerate

    assign tap_out     = cell_tap[NUM_CELLS-1];
    assign cascade_out = cell_last[NUM_CELLS-1];

    tapdl_out_stage #(
        .REGISTERED (OUT_REG)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .d        (tap_out),
        .q        (tap_out_q)
    );
endmodule

// File: rtl/tapdl_chain_chk.sv
`timescale 1ns/1ps
// Checker bound to every tapdl_chain instance.
module tapdl_chain_chk #(
    parameter int unsigned SEL_BUS_W = 12,
    parameter bit          OUT_REG   = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shift_en,
    input logic [SEL_BUS_W-1:0] tap_sel,
    input logic                 tap_out,
    input logic                 tap_out_q,
    input logic                 cascade_out
);
    localparam bit HAS_Q = OUT_REG;

    AST_IDLE_CASCADE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cascade_out)); // R2

    AST_IDLE_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> (!$stable(tap_sel) || $stable(tap_out))); // R2

    AST_QREG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_Q && shift_en) |=> (tap_out_q == $past(tap_out))); // R6

    AST_QREG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_Q && !shift_en) |=> $stable(tap_out_q)); // R6

    AST_TAP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({tap_out, cascade_out})); // R1
endmodule

bind tapdl_chain tapdl_chain_chk #(
    .SEL_BUS_W (NUM_CELLS * SEL_W),
    .OUT_REG   (OUT_REG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en    (shift_en),
    .tap_sel     (tap_sel),
    .tap_out     (tap_out),
    .tap_out_q   (tap_out_q),
    .cascade_out (cascade_out)
);

// File: tb/tapdl_chain_test.sv
`timescale 1ns/1ps
module tapdl_chain_test;
    localparam int NC = 3;
    localparam int D  = 16;
    localparam logic [15:0] INITP = 16'hB38E;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, shift_en, din;
    logic [11:0] sel;
    logic [7:0]  sel_f;
    logic        tap_out, tap_out_q, cascade_out;
    logic        f_tap, f_q, f_casc;

    tapdl_chain #(
        .NUM_CELLS (NC), .INIT_BITS (INITP), .OUT_REG (1'b1),
        .LINK_MODE (tapdl_pkg::LINK_TAP)
    ) uut (
        .clk (clk), .rst_n (rst_n), .shift_en (shift_en), .din (din),
        .tap_sel (sel), .tap_out (tap_out), .tap_out_q (tap_out_q),
        .cascade_out (cascade_out)
    );

    tapdl_chain #(
        .NUM_CELLS (2), .INIT_BITS (16'h0000), .OUT_REG (1'b0),
        .LINK_MODE (tapdl_pkg::LINK_FULL)
    ) uut_full (
        .clk (clk), .rst_n (rst_n), .shift_en (shift_en), .din (din),
        .tap_sel (sel_f), .tap_out (f_tap), .tap_out_q (f_q),
        .cascade_out (f_casc)
    );

    // Reference: per-cell stage queues for uut, input history for sums.
    bit mdl [NC][D];
    bit hist [128];
    bit exp_q;
    int total = 0;
    int bad   = 0;

    function automatic bit exp_tap();
        return mdl[NC-1][sel[4*(NC-1) +: 4]];
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " tap_out R1"}, tap_out, exp_tap());
        chk({tag, " cascade_out R3"}, cascade_out, mdl[NC-1][D-1]);
        chk({tag, " tap_out_q R6"}, tap_out_q, exp_q);
        chk({tag, " full-link tap R9"}, f_tap, hist[16 + int'(sel_f[7:4])]);
        chk({tag, " full-link cascade R9"}, f_casc, hist[31]);
        chk({tag, " pass-through q R9"}, f_q, f_tap);
    endtask

    task automatic commit(bit en);
        bit ins [NC];
        if (!rst_n) exp_q = 1'b0;
        else if (en) exp_q = exp_tap();
        if (en) begin
            ins[0] = din;
            for (int c = 1; c < NC; c++) ins[c] = mdl[c-1][sel[4*(c-1) +: 4]];
            for (int c = 0; c < NC; c++) begin
                for (int j = D-1; j > 0; j--) mdl[c][j] = mdl[c][j-1];
                mdl[c][0] = ins[c];
            end
            for (int j = 127; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = din;
        end
    endtask

    task automatic step(string tag, bit en, bit d);
        @(negedge clk);
        shift_en = en;
        din      = d;
        #1;
        check_all(tag);
        @(posedge clk);
        #1;
        commit(en);
    endtask

    task automatic held_run(string tag, logic [11:0] s, int n);
        sel = s;
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; shift_en = 1'b0; din = 1'b0; sel = '0; sel_f = '0;
        exp_q = 1'b0;
        for (int c = 0; c < NC; c++)
            for (int j = 0; j < D; j++) mdl[c][j] = INITP[j];
        for (int j = 0; j < 128; j++) hist[j] = 1'b0;

        @(posedge clk);
        #1;
        // R5 and R6 under reset: stages keep INIT_BITS, output flop cleared.
        chk("R5 initial cascade", cascade_out, INITP[15]);
        chk("R5 initial tap sel 0", tap_out, INITP[0]);
        chk("R6 reset clears q", tap_out_q, 1'b0);
        for (int i = 0; i < 3; i++) step("R5 reset", 1'b0, 1'($urandom));
        rst_n = 1'b1;

        // R4: select sweep with no shift, value visible in same cycle.
        for (int k = 0; k < 16; k++) begin
            sel   = {4'(k), 8'h00};
            sel_f = {4'(15 - k), 4'(k)};
            step("R4 sweep", 1'b0, 1'($urandom));
            chk("R4 tap follows select", tap_out, INITP[k]);
        end

        // R1: random shifting, enables and select changes.
        for (int i = 0; i < 800; i++) begin
            if ($urandom % 8 == 0) sel = 12'($urandom);
            if ($urandom % 8 == 0) sel_f = 8'($urandom);
            step("R1 random", ($urandom % 4) != 0, 1'($urandom));
        end

        // R2: long idle with toggling input.
        sel = 12'h5A3;
        step("R2 pre-idle", 1'b1, 1'b1);
        begin
            logic t0, c0, q0;
            t0 = tap_out; c0 = cascade_out; q0 = tap_out_q;
            for (int i = 0; i < 20; i++) begin
                step("R2 idle", 1'b0, 1'(i));
                chk("R2 idle tap hold", tap_out, t0);
                chk("R2 idle cascade hold", cascade_out, c0);
                chk("R2 idle q hold", tap_out_q, q0);
            end
        end

        // R8: uneven selects, last cell selects 9.
        held_run("R8 held", {4'd9, 4'd0, 4'd0}, 60);
        chk("R8 cascade position", cascade_out, hist[17]);
        chk("R7 sum delay 12", tap_out, hist[11]);
        chk("R6 q one behind", tap_out_q, hist[12]);
        held_run("R8 held", {4'd0, 4'd0, 4'd9}, 60);
        chk("R8 cascade first cell 9", cascade_out, hist[26]);
        chk("R7 sum delay 12 mirrored", tap_out, hist[11]);

        // R7: several held select sets.
        held_run("R7 held", {4'd3, 4'd7, 4'd2}, 60);
        chk("R7 sum delay 15", tap_out, hist[14]);
        chk("R6 q delay 16", tap_out_q, hist[15]);
        held_run("R7 held", 12'hFFF, 60);
        chk("R7 max delay 48", tap_out, hist[47]);
        chk("R8 max cascade", cascade_out, hist[47]);
        chk("R6 q delay 49", tap_out_q, hist[48]);
        held_run("R7 held", 12'h000, 10);
        chk("R7 min delay 3", tap_out, hist[2]);

        // R6: reset clears only the output flop.
        rst_n = 1'b0;
        step("R6 reset mid-run", 1'b0, 1'b1);
        chk("R6 q cleared", tap_out_q, 1'b0);
        chk("R5 stages survive reset", tap_out, hist[2]);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule